// File: doc/BRIEF.md
# Hysteretic PLL Loss-of-Lock Detector

This block watches a reference clock and a PLL feedback clock and decides whether the loop has lost phase lock. Both clocks are brought into a fast sampling clock domain through a synchronizer. There, a rising-edge detector turns each rising edge into a one-tick pulse. A measurement opens on the first edge of either clock and closes on the matching edge of the other clock. The result is the number of sampling ticks between the two edges, taken as an unsigned magnitude, so either clock may lead.

A single flag reports loss of lock. The flag is set when a completed measurement is wider than a set threshold. It is cleared only when a completed measurement is narrower than a lower clear threshold. Results between the two thresholds leave the flag as it was. Both thresholds are run-time inputs given in sampling ticks. With a 1 GHz sampling clock, a 4 ns set point and a 2 ns clear point are the values 4 and 2. The compared clocks are normally the divided phase-detector clocks, and they should run at 5 MHz or more so that jitter does not raise false flags.

A measurement that never finds its partner edge is a timeout. This happens when the leading clock shows a second edge first, or when the tick counter reaches its ceiling. A timeout counts as wider than any threshold. The last measured gap is available on a debug output.

Top module: `pll_lock_monitor`

## Requirements
- R1: While reset is asserted, and after it is released until the first measurement completes, `lol` is 1 and `gap_q` is 0.
- R2: A measurement gives the number of sampling ticks between a reference rising edge and the following feedback rising edge, whichever clock leads. One cycle after the measurement completes, `gap_q` shows that count.
- R3: When a completed measurement is greater than `set_thr`, `lol` becomes 1.
- R4: When a completed measurement is less than `clr_thr`, `lol` becomes 0.
- R5: When a completed measurement lies between `clr_thr` and `set_thr`, both ends included, `lol` keeps its value. The inputs must satisfy `set_thr` > `clr_thr`.
- R6: If the leading clock shows a second rising edge before the partner edge arrives, the measurement ends as a timeout. `gap_q` then shows all ones (2^TW-1) and `lol` becomes 1.
- R7: If no partner edge arrives within 2^TW-1 ticks of the leading edge, the measurement ends as a timeout, with the same outputs as R6.
- R8: `lol` changes only on the cycle after a measurement completes.
- R9: Rising edges of both clocks in the same sampling tick give a gap of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low reset |
| ref_in | input | 1 | Reference clock, asynchronous |
| fb_in | input | 1 | PLL feedback clock, asynchronous |
| set_thr | input | TW | Gap above which lock is declared lost, in ticks |
| clr_thr | input | TW | Gap below which lock is declared regained, in ticks |
| lol | output | 1 | Loss-of-lock flag, 1 means unlocked |
| gap_q | output | TW | Last measured gap in ticks (0 when SHOW_GAP is 0) |

## Verification
Directed edge pairs step the gap through values below, between, equal to and above the thresholds, with the reference leading and then the feedback leading. This shows that the hysteresis holds its value in the middle band and that the sign of the phase error does not matter. Coincident edges, a repeated leading edge and a missing partner edge check the zero-gap case and both timeout paths, which must read as maximum gap. Random gaps, leaders and threshold pairs, taken from a fixed seed, are then compared against a bench model of the flag. This exposes wrong comparison directions or off-by-one errors at the threshold boundaries.

// File: rtl/lol_pkg.sv
package lol_pkg;
   typedef enum logic [1:0] {
      MS_IDLE     = 2'd0,
      MS_WAIT_FB  = 2'd1,
      MS_WAIT_REF = 2'd2
   } meas_st_e;
endpackage

// File: rtl/lol_edge_sync.sv
module lol_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   initial begin
      if (STAGES < 2) $error("lol_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[0] <= 1'b0;
      else        pipe[0] <= din;
   end

   for (genvar g = 1; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[g] <= 1'b0;
         else        pipe[g] <= pipe[g-1];
      end
   end

   assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/lol_gap_meter.sv
module lol_gap_meter
   import lol_pkg::*;
#(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ref_rise,
   input  logic          fb_rise,
   output logic          done,
   output logic          tmo,
   output logic [TW-1:0] gap
);
   localparam logic [TW-1:0] MAXC = {TW{1'b1}};
   localparam logic [TW-1:0] ONE  = TW'(1);

   meas_st_e      st;
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= MS_IDLE;
         cnt  <= '0;
         done <= 1'b0;
         tmo  <= 1'b0;
         gap  <= '0;
      end else begin
         done <= 1'b0;
         tmo  <= 1'b0;
         case (st)
            MS_IDLE: begin
               if (ref_rise && fb_rise) begin
                  done <= 1'b1;
                  gap  <= '0;
               end else if (ref_rise) begin
                  st  <= MS_WAIT_FB;
                  cnt <= ONE;
               end else if (fb_rise) begin
                  st  <= MS_WAIT_REF;
                  cnt <= ONE;
               end
            end
            MS_WAIT_FB: begin
               if (fb_rise) begin
                  done <= 1'b1;
                  gap  <= cnt;
                  st   <= MS_IDLE;
               end else if (ref_rise || cnt == MAXC) begin
                  done <= 1'b1;
                  tmo  <= 1'b1;
                  gap  <= MAXC;
                  st   <= MS_IDLE;
               end else begin
                  cnt <= cnt + ONE;
               end
            end
            MS_WAIT_REF: begin
               if (ref_rise) begin
                  done <= 1'b1;
                  gap  <= cnt;
                  st   <= MS_IDLE;
               end else if (fb_rise || cnt == MAXC) begin
                  done <= 1'b1;
                  tmo  <= 1'b1;
                  gap  <= MAXC;
                  st   <= MS_IDLE;
               end else begin
                  cnt <= cnt + ONE;
               end
            end
            default: st <= MS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lol_hyst.sv
module lol_hyst #(
   parameter int TW       = 8,
   parameter bit SHOW_GAP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          done,
   input  logic          tmo,
   input  logic [TW-1:0] gap,
   input  logic [TW-1:0] set_thr,
   input  logic [TW-1:0] clr_thr,
   output logic          lol,
   output logic [TW-1:0] gap_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lol <= 1'b1;
      end else if (done) begin
         if (tmo || gap > set_thr) lol <= 1'b1;
         else if (gap < clr_thr)   lol <= 1'b0;
      end
   end

   if (SHOW_GAP) begin : g_gap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    gap_q <= '0;
         else if (done) gap_q <= gap;
      end
   end else begin : g_nogap
      assign gap_q = '0;
   end
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
   parameter int TW       = 8,
   parameter int SYNC_STG = 2,
   parameter bit SHOW_GAP = 1'b1
) (
   input  logic          clk_smp,
   input  logic          rst_n,
   input  logic          ref_in,
   input  logic          fb_in,
   input  logic [TW-1:0] set_thr,
   input  logic [TW-1:0] clr_thr,
   output logic          lol,
   output logic [TW-1:0] gap_q
);
   initial begin
      if (TW < 2 || TW > 24) $error("pll_lock_monitor: TW out of range");
   end

   logic          ref_rise;
   logic          fb_rise;
   logic          m_done;
   logic          m_tmo;
   logic [TW-1:0] m_gap;

   lol_edge_sync #(.STAGES(SYNC_STG)) u_sync_ref (
      .clk(clk_smp), .rst_n(rst_n), .din(ref_in), .rise(ref_rise)
   );

   lol_edge_sync #(.STAGES(SYNC_STG)) u_sync_fb (
      .clk(clk_smp), .rst_n(rst_n), .din(fb_in), .rise(fb_rise)
   );

   lol_gap_meter #(.TW(TW)) u_meter (
      .clk(clk_smp), .rst_n(rst_n), .ref_rise(ref_rise), .fb_rise(fb_rise),
      .done(m_done), .tmo(m_tmo), .gap(m_gap)
   );

   lol_hyst #(.TW(TW), .SHOW_GAP(SHOW_GAP)) u_hyst (
      .clk(clk_smp), .rst_n(rst_n), .done(m_done), .tmo(m_tmo), .gap(m_gap),
      .set_thr(set_thr), .clr_thr(clr_thr), .lol(lol), .gap_q(gap_q)
   );
endmodule

// File: rtl/pll_lock_monitor_chk.sv
module pll_lock_monitor_chk #(
   parameter int TW       = 8,
   parameter bit SHOW_GAP = 1'b1
) (
   input logic          clk_smp,
   input logic          rst_n,
   input logic          m_done,
   input logic          m_tmo,
   input logic [TW-1:0] m_gap,
   input logic [TW-1:0] set_thr,
   input logic [TW-1:0] clr_thr,
   input logic          lol,
   input logic [TW-1:0] gap_q
);
   AST_RESET_UNLOCKED: assert property (@(posedge clk_smp) !rst_n |=> lol); // R1
   AST_SET_ON_WIDE: assert property (@(posedge clk_smp) disable iff (!rst_n)
      (m_done && !m_tmo && m_gap > set_thr) |=> lol); // R3
   AST_CLR_ON_NARROW: assert property (@(posedge clk_smp) disable iff (!rst_n)
      (m_done && !m_tmo && m_gap < clr_thr) |=> !lol); // R4
   AST_HOLD_MID: assert property (@(posedge clk_smp) disable iff (!rst_n)
      (m_done && !m_tmo && m_gap >= clr_thr && m_gap <= set_thr) |=> $stable(lol)); // R5
   AST_THR_ORDER: assert property (@(posedge clk_smp) disable iff (!rst_n)
      set_thr > clr_thr); // R5
   AST_TMO_SETS: assert property (@(posedge clk_smp) disable iff (!rst_n)
      (m_done && m_tmo) |=> (lol && (!SHOW_GAP || gap_q == {TW{1'b1}}))); // R6
   AST_CHANGE_ONLY_ON_DONE: assert property (@(posedge clk_smp) disable iff (!rst_n)
      !m_done |=> $stable(lol)); // R8
endmodule

bind pll_lock_monitor pll_lock_monitor_chk #(.TW(TW), .SHOW_GAP(SHOW_GAP)) u_chk (
   .clk_smp(clk_smp), .rst_n(rst_n), .m_done(m_done), .m_tmo(m_tmo), .m_gap(m_gap),
   .set_thr(set_thr), .clr_thr(clr_thr), .lol(lol), .gap_q(gap_q)
);

// File: tb/pll_lock_monitor_tb.sv
module pll_lock_monitor_tb;
   localparam int TW   = 8;
   localparam int MAXG = (1 << TW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ref_in = 1'b0;
   logic          fb_in = 1'b0;
   logic [TW-1:0] set_thr = TW'(4);
   logic [TW-1:0] clr_thr = TW'(2);
   logic          lol;
   logic [TW-1:0] gap_q;

   int checks = 0;
   int errors = 0;
   bit exp_lol = 1'b1;

   always #5 clk = ~clk;

   pll_lock_monitor #(.TW(TW)) u_dut (
      .clk_smp(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
      .set_thr(set_thr), .clr_thr(clr_thr), .lol(lol), .gap_q(gap_q)
   );

   function automatic bit next_lol(bit cur, int g, bit timeout, int s, int c);
      if (timeout || g > s) return 1'b1;
      if (g < c)            return 1'b0;
      return cur;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_thresholds(int s, int c);
      @(negedge clk);
      set_thr = TW'(s);
      clr_thr = TW'(c);
   endtask

   task automatic pair(bit fb_lead, int k);
      for (int i = 0; i <= k; i++) begin
         @(negedge clk);
         ref_in = fb_lead ? (i == k) : (i == 0);
         fb_in  = fb_lead ? (i == 0) : (i == k);
      end
      @(negedge clk);
      ref_in = 1'b0;
      fb_in  = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   task automatic gap_case(string req, bit fb_lead, int k);
      pair(fb_lead, k);
      exp_lol = next_lol(exp_lol, k, 1'b0, int'(set_thr), int'(clr_thr));
      check(req, int'(lol), int'(exp_lol));
      check({req, " gap R2"}, int'(gap_q), k);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd1234);
      repeat (3) @(negedge clk);
      check("R1 lol in reset", int'(lol), 1);
      check("R1 gap in reset", int'(gap_q), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R1 lol after reset", int'(lol), 1);

      gap_case("R4 gap1 clears", 1'b0, 1);
      gap_case("R5 gap3 holds 0", 1'b0, 3);
      gap_case("R5 gap4 equal set holds", 1'b0, 4);
      gap_case("R3 gap5 sets", 1'b0, 5);
      gap_case("R5 gap3 holds 1", 1'b0, 3);
      gap_case("R5 gap2 equal clr holds", 1'b0, 2);
      gap_case("R9 coincident clears", 1'b0, 0);
      gap_case("R3 fb lead gap6 sets", 1'b1, 6);
      gap_case("R4 fb lead gap1 clears", 1'b1, 1);

      // R6: second reference edge before any feedback edge
      @(negedge clk); ref_in = 1'b1;
      @(negedge clk); ref_in = 1'b0;
      repeat (2) @(negedge clk);
      ref_in = 1'b1;
      @(negedge clk); ref_in = 1'b0;
      repeat (10) @(negedge clk);
      exp_lol = 1'b1;
      check("R6 repeat lead lol", int'(lol), 1);
      check("R6 repeat lead gap", int'(gap_q), MAXG);

      gap_case("R4 recover", 1'b1, 0);

      // R7: partner edge never arrives
      @(negedge clk); fb_in = 1'b1;
      @(negedge clk); fb_in = 1'b0;
      repeat (MAXG + 12) @(negedge clk);
      exp_lol = 1'b1;
      check("R7 missing partner lol", int'(lol), 1);
      check("R7 missing partner gap", int'(gap_q), MAXG);

      // R8: lol stays put with no edges
      repeat (30) @(negedge clk);
      check("R8 idle stable", int'(lol), 1);

      for (int n = 0; n < 60; n++) begin
         int s, c, k;
         bit lead;
         s = 3 + int'($urandom % 10);
         c = 1 + int'($urandom % (s - 1));
         k = int'($urandom % 16);
         lead = 1'($urandom % 2);
         set_thresholds(s, c);
         gap_case("R3/R4/R5 random", lead, k);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule